// File: doc/BRIEF.md
# Secondary Core Power-Up Sequencer

This block brings one secondary processor core from fully off to running. Software or a boot controller gives it a one-cycle start pulse. The block then waits until the shared-cache sequencer says the cache is powered. Once that is true, it walks the core's power controls through a fixed, timed order:

- the power-gate head switches close in two steps;
- the core-memory clamp is released and the core-memory head switch closes;
- the core clamp is released;
- core reset is released;
- power-up-done is raised to the core.

If the cache sequencer reports a failure instead, the block gives up. It flags an error and leaves every control line untouched.

The `mode_i` input picks one of two timing profiles and is sampled with the start pulse. In the standard profile (mode 0), the second head-switch group follows the first after a fixed skew of `SKEW_CYC` cycles. Each later settle wait lasts two microseconds. In the staged profile (mode 1), every wait lasts one microsecond, including the gap between the two head-switch groups. One microsecond equals `CYC_PER_US` clock cycles.

After the sequence completes, the block holds the powered-up control state until reset.

Top module: `cpu_pup_seq`

## Requirements
- R1: After reset the control lines are: `core_rst_o`=1, `mem_clamp_o`=1, `core_clamp_o`=1, `hs_few_o`=0, `hs_rest_o`=0, `mem_hs_o`=0, `pwrdup_o`=0. The status lines `busy_o`, `done_o` and `err_o` are all 0.
- R2: After a start pulse, no control line changes while `cache_ready_i` is low. `hs_few_o` rises in the cycle after the first cycle in which `cache_ready_i` is seen high.
- R3: If `cache_fail_i` is high while the block is waiting for the cache, the following hold:
  - the control lines do not change;
  - `err_o` pulses for exactly one cycle and `busy_o` falls in that same cycle;
  - a later start pulse is accepted.
  - `cache_fail_i` takes priority over `cache_ready_i`.
- R4: In mode 0, `hs_rest_o` rises `SKEW_CYC` cycles after `hs_few_o`.
- R5: In mode 0, `mem_clamp_o` falls 2·`CYC_PER_US` cycles after `hs_rest_o` rises, and `mem_hs_o` rises one cycle after that.
- R6: In mode 0, `core_clamp_o` falls 2·`CYC_PER_US` cycles after `mem_hs_o` rises. `core_rst_o` falls 2·`CYC_PER_US` cycles after that.
- R7: In mode 1, every wait in R4 to R6 lasts `CYC_PER_US` cycles. The one-cycle step between `mem_clamp_o` and `mem_hs_o` stays one cycle.
- R8: `pwrdup_o` rises exactly one cycle after `core_rst_o` falls. `done_o` pulses for one cycle in that same cycle. The final control state is then held.
- R9: A start pulse has no effect while the block is busy or after the sequence has completed.
- R10: `core_rst_o` is low only when both clamps are released and all head switches are closed. `hs_rest_o` is never high without `hs_few_o`.
- R11: The profile is taken from `mode_i` at the start pulse. Later changes of `mode_i` do not alter the running sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle request to power up the core |
| mode_i | input | 1 | Profile select: 0 standard skew, 1 staged head switches |
| cache_ready_i | input | 1 | Shared cache is powered |
| cache_fail_i | input | 1 | Shared cache power-up failed |
| core_rst_o | output | 1 | Core reset, 1 = held in reset |
| hs_few_o | output | 1 | First head-switch group enable |
| hs_rest_o | output | 1 | Remaining head-switch group enable |
| mem_clamp_o | output | 1 | Core-memory clamp, 1 = clamped |
| mem_hs_o | output | 1 | Core-memory head switch, 1 = closed |
| core_clamp_o | output | 1 | Core clamp, 1 = clamped |
| pwrdup_o | output | 1 | Power-up-done indication to the core |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | One-cycle abort pulse on cache failure |

## Verification
A state register that jumps or stalls shows up at the ports directly. Some control edge then arrives at the wrong cycle offset from the previous one, and the bench measures each edge to the exact cycle. A timer loaded with the wrong profile, or a profile that follows `mode_i` during a run, shifts the release edges by the difference between one and two microseconds within the first wait. A misordered decode breaks the reset-release invariants in the cycle where it happens.

// File: rtl/cps_pkg.sv
package cps_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_WAITC,
        ST_HS1,
        ST_HS2,
        ST_MCLMP,
        ST_MHS,
        ST_CCLMP,
        ST_RREL,
        ST_ON
    } st_e;

    typedef struct packed {
        logic core_rst;
        logic hs_few;
        logic hs_rest;
        logic mem_clamp;
        logic mem_hs;
        logic core_clamp;
        logic pwrdup;
    } ctl_t;

    // Control levels held in each step; every step keeps the previous releases.
    function automatic ctl_t ctl_of(st_e s);
        ctl_t c;
        c = '{core_rst: 1'b1, hs_few: 1'b0, hs_rest: 1'b0, mem_clamp: 1'b1,
              mem_hs: 1'b0, core_clamp: 1'b1, pwrdup: 1'b0};
        if (s >= ST_HS1)   c.hs_few     = 1'b1;
        if (s >= ST_HS2)   c.hs_rest    = 1'b1;
        if (s >= ST_MCLMP) c.mem_clamp  = 1'b0;
        if (s >= ST_MHS)   c.mem_hs     = 1'b1;
        if (s >= ST_CCLMP) c.core_clamp = 1'b0;
        if (s >= ST_RREL)  c.core_rst   = 1'b0;
        if (s >= ST_ON)    c.pwrdup     = 1'b1;
        return c;
    endfunction

    function automatic logic is_busy(st_e s);
        return (s != ST_IDLE) && (s != ST_ON);
    endfunction

endpackage

// File: rtl/cps_timer.sv
module cps_timer #(
    parameter int TW = 5
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          load_i,
    input  logic [TW-1:0] val_i,
    output logic          zero_o
);

    logic [TW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i)
            cnt_d = val_i;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    assign zero_o = (cnt_q == '0);

    // Counter never wraps from zero without a reload.
    AST_TMR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (zero_o && !load_i) |=> zero_o); // R4

endmodule

// File: rtl/cps_ctrl.sv
module cps_ctrl
    import cps_pkg::*;
#(
    parameter int TW = 5,
    parameter logic [TW-1:0] SKEW_LD = '0,
    parameter logic [TW-1:0] US1_LD  = '0,
    parameter logic [TW-1:0] US2_LD  = '0
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          start_i,
    input  logic          mode_i,
    input  logic          cache_ready_i,
    input  logic          cache_fail_i,
    input  logic          tmr_zero_i,
    output logic          tmr_load_o,
    output logic [TW-1:0] tmr_val_o,
    output ctl_t          ctl_o,
    output logic          busy_o,
    output logic          done_o,
    output logic          err_o
);

    typedef struct packed {
        st_e  st;
        logic mode;
        ctl_t ctl;
        logic busy;
        logic done;
        logic err;
    } regs_t;

    regs_t r_d, r_q;
    logic [TW-1:0] wait_ld;

    // Settle time for the memory and clamp steps depends on the profile.
    assign wait_ld = r_q.mode ? US1_LD : US2_LD;

    always_comb begin
        r_d        = r_q;
        r_d.done   = 1'b0;
        r_d.err    = 1'b0;
        tmr_load_o = 1'b0;
        tmr_val_o  = '0;
        unique case (r_q.st)
            ST_IDLE: if (start_i) begin
                r_d.st   = ST_WAITC;
                r_d.mode = mode_i;
            end
            ST_WAITC: begin
                if (cache_fail_i) begin
                    r_d.st  = ST_IDLE;
                    r_d.err = 1'b1;
                end else if (cache_ready_i) begin
                    r_d.st     = ST_HS1;
                    tmr_load_o = 1'b1;
                    tmr_val_o  = r_q.mode ? US1_LD : SKEW_LD;
                end
            end
            ST_HS1: if (tmr_zero_i) begin
                r_d.st     = ST_HS2;
                tmr_load_o = 1'b1;
                tmr_val_o  = wait_ld;
            end
            ST_HS2: if (tmr_zero_i) r_d.st = ST_MCLMP;
            ST_MCLMP: begin
                r_d.st     = ST_MHS;
                tmr_load_o = 1'b1;
                tmr_val_o  = wait_ld;
            end
            ST_MHS: if (tmr_zero_i) begin
                r_d.st     = ST_CCLMP;
                tmr_load_o = 1'b1;
                tmr_val_o  = wait_ld;
            end
            ST_CCLMP: if (tmr_zero_i) r_d.st = ST_RREL;
            ST_RREL: begin
                r_d.st   = ST_ON;
                r_d.done = 1'b1;
            end
            ST_ON:   r_d.st = ST_ON;
            default: r_d.st = ST_IDLE;
        endcase
        r_d.ctl  = ctl_of(r_d.st);
        r_d.busy = is_busy(r_d.st);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            r_q.st   <= ST_IDLE;
            r_q.mode <= 1'b0;
            r_q.ctl  <= ctl_of(ST_IDLE);
            r_q.busy <= 1'b0;
            r_q.done <= 1'b0;
            r_q.err  <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign ctl_o  = r_q.ctl;
    assign busy_o = r_q.busy;
    assign done_o = r_q.done;
    assign err_o  = r_q.err;

    AST_NO_EARLY_SWITCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (r_q.st == ST_WAITC && !cache_ready_i) |=> !ctl_o.hs_few); // R2
    AST_ERR_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        err_o |-> (!busy_o && $stable(ctl_o))); // R3
    AST_ERR_ONCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        err_o |=> !err_o); // R3
    AST_DONE_ONCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o); // R8
    AST_PWRDUP_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(ctl_o.pwrdup) |-> ($past(!ctl_o.core_rst) && done_o)); // R8
    AST_RST_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !ctl_o.core_rst |-> (!ctl_o.core_clamp && !ctl_o.mem_clamp
                             && ctl_o.hs_rest && ctl_o.mem_hs)); // R10
    AST_HS_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ctl_o.hs_rest |-> ctl_o.hs_few); // R10
    AST_MODE_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && $past(busy_o)) |-> $stable(r_q.mode)); // R11
    AST_STATUS_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0({done_o, err_o})); // R8

endmodule

// File: rtl/cpu_pup_seq.sv
module cpu_pup_seq
    import cps_pkg::*;
#(
    parameter int CYC_PER_US = 10,
    parameter int SKEW_CYC   = 16
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic start_i,
    input  logic mode_i,
    input  logic cache_ready_i,
    input  logic cache_fail_i,
    output logic core_rst_o,
    output logic hs_few_o,
    output logic hs_rest_o,
    output logic mem_clamp_o,
    output logic mem_hs_o,
    output logic core_clamp_o,
    output logic pwrdup_o,
    output logic busy_o,
    output logic done_o,
    output logic err_o
);

    localparam int US2_CYC  = 2 * CYC_PER_US;
    localparam int MAX_CYC  = (US2_CYC > SKEW_CYC) ? US2_CYC : SKEW_CYC;
    localparam int TW       = $clog2(MAX_CYC + 1);
    localparam logic [TW-1:0] SKEW_LD = TW'(SKEW_CYC - 1);
    localparam logic [TW-1:0] US1_LD  = TW'(CYC_PER_US - 1);
    localparam logic [TW-1:0] US2_LD  = TW'(US2_CYC - 1);

    logic          tmr_load, tmr_zero;
    logic [TW-1:0] tmr_val;
    ctl_t          ctl;

    cps_timer #(.TW(TW)) u_tmr (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .load_i (tmr_load),
        .val_i  (tmr_val),
        .zero_o (tmr_zero)
    );

    cps_ctrl #(
        .TW     (TW),
        .SKEW_LD(SKEW_LD),
        .US1_LD (US1_LD),
        .US2_LD (US2_LD)
    ) u_ctrl (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .start_i      (start_i),
        .mode_i       (mode_i),
        .cache_ready_i(cache_ready_i),
        .cache_fail_i (cache_fail_i),
        .tmr_zero_i   (tmr_zero),
        .tmr_load_o   (tmr_load),
        .tmr_val_o    (tmr_val),
        .ctl_o        (ctl),
        .busy_o       (busy_o),
        .done_o       (done_o),
        .err_o        (err_o)
    );

    assign core_rst_o   = ctl.core_rst;
    assign hs_few_o     = ctl.hs_few;
    assign hs_rest_o    = ctl.hs_rest;
    assign mem_clamp_o  = ctl.mem_clamp;
    assign mem_hs_o     = ctl.mem_hs;
    assign core_clamp_o = ctl.core_clamp;
    assign pwrdup_o     = ctl.pwrdup;

    AST_RESET_SAFE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !busy_o && !pwrdup_o |-> (core_rst_o && mem_clamp_o && core_clamp_o)); // R1

endmodule

// File: tb/sim_cpu_pup_seq.sv
module sim_cpu_pup_seq;

    localparam int CPU  = 10;
    localparam int SKEW = 16;
    localparam logic [6:0] CTL_OFF = 7'b1001010;
    localparam logic [6:0] CTL_ON  = 7'b0110101;

    logic clk = 1'b0, rst_n = 1'b0;
    logic start = 1'b0, mode = 1'b0, cready = 1'b0, cfail = 1'b0;
    logic core_rst, hs_few, hs_rest, mem_clamp, mem_hs, core_clamp, pwrdup;
    logic busy, done, err;
    int checks = 0, errors = 0;

    always #5ns clk = ~clk;

    cpu_pup_seq #(.CYC_PER_US(CPU), .SKEW_CYC(SKEW)) u0 (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start), .mode_i(mode),
        .cache_ready_i(cready), .cache_fail_i(cfail),
        .core_rst_o(core_rst), .hs_few_o(hs_few), .hs_rest_o(hs_rest),
        .mem_clamp_o(mem_clamp), .mem_hs_o(mem_hs), .core_clamp_o(core_clamp),
        .pwrdup_o(pwrdup), .busy_o(busy), .done_o(done), .err_o(err)
    );

    function automatic logic [6:0] ctl_vec();
        return {core_rst, hs_few, hs_rest, mem_clamp, mem_hs, core_clamp, pwrdup};
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; start = 1'b0; cready = 1'b0; cfail = 1'b0; mode = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic test_reset();
        do_reset();
        check("R1 controls", int'(ctl_vec()), int'(CTL_OFF));
        check("R1 status", int'({busy, done, err}), 0);
    endtask

    // Runs one power-up; cache ready at cycle d; mode toggled and start re-pulsed mid-run.
    task automatic run_seq(input logic m, input int d, input string tag);
        int t[7];
        int e[7];
        int t_done = -1, n_done = 0;
        int a, b, c;
        for (int i = 0; i < 7; i++) t[i] = -1;
        mode = m; cready = 1'b0;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        for (int n = 0; n < 150; n++) begin
            if (n == d) cready = 1'b1;
            if (n == 5) mode = ~m;          // R11 stimulus
            start = (n == 30);              // R9 stimulus while busy
            if (hs_few     && t[0] < 0) t[0] = n;
            if (hs_rest    && t[1] < 0) t[1] = n;
            if (!mem_clamp && t[2] < 0) t[2] = n;
            if (mem_hs     && t[3] < 0) t[3] = n;
            if (!core_clamp&& t[4] < 0) t[4] = n;
            if (!core_rst  && t[5] < 0) t[5] = n;
            if (pwrdup     && t[6] < 0) t[6] = n;
            if (done) begin n_done++; t_done = n; end
            @(negedge clk);
        end
        start = 1'b0; cready = 1'b0; mode = 1'b0;
        a = m ? CPU : SKEW;
        b = m ? CPU : 2 * CPU;
        c = m ? CPU : 2 * CPU;
        e[0] = d + 1;
        e[1] = e[0] + a;
        e[2] = e[1] + b;
        e[3] = e[2] + 1;
        e[4] = e[3] + c;
        e[5] = e[4] + c;
        e[6] = e[5] + 1;
        check({tag, " R2 hs_few edge"}, t[0], e[0]);
        check({tag, (m ? " R7" : " R4"), " hs_rest edge"}, t[1], e[1]);
        check({tag, (m ? " R7" : " R5"), " mem_clamp edge"}, t[2], e[2]);
        check({tag, " R5 mem_hs edge"}, t[3], e[3]);
        check({tag, (m ? " R7" : " R6"), " core_clamp edge"}, t[4], e[4]);
        check({tag, (m ? " R7" : " R6"), " core_rst edge"}, t[5], e[5]);
        check({tag, " R8 pwrdup edge"}, t[6], e[6]);
        check({tag, " R8 done cycle"}, t_done, e[6]);
        check({tag, " R8 R9 R11 done count"}, n_done, 1);
        check({tag, " R8 final controls"}, int'(ctl_vec()), int'(CTL_ON));
    endtask

    task automatic test_after_done();
        int n_done = 0;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        for (int n = 0; n < 30; n++) begin
            if (done || busy) n_done++;
            @(negedge clk);
        end
        check("R9 start after completion ignored", n_done, 0);
        check("R9 controls held", int'(ctl_vec()), int'(CTL_ON));
    endtask

    task automatic test_fail();
        int t_err = -1, n_err = 0, moved = 0;
        do_reset();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        for (int n = 0; n < 20; n++) begin
            if (n == 3) begin cfail = 1'b1; cready = 1'b1; end  // fail wins
            if (n == 4) begin cfail = 1'b0; cready = 1'b0; end
            if (err) begin n_err++; t_err = n; check("R3 busy low with err", int'(busy), 0); end
            if (ctl_vec() != CTL_OFF) moved++;
            @(negedge clk);
        end
        check("R3 err cycle", t_err, 4);
        check("R3 err count", n_err, 1);
        check("R3 controls untouched", moved, 0);
        run_seq(1'b0, 0, "after-fail R3");
    endtask

    initial begin
        #(1_000_000ns);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        test_reset();
        do_reset(); run_seq(1'b0, 0, "std");
        test_after_done();
        do_reset(); run_seq(1'b1, 0, "staged");
        do_reset(); run_seq(1'b0, 7, "std-late R2");
        do_reset(); run_seq(1'b1, 4, "staged-late R2");
        test_fail();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule